// File: doc/BRIEF.md
# Vectored Bus Interrupter with Acknowledge Daisy-Chain

This block sits between four local interrupting devices and a shared system bus that carries seven prioritised, active-low interrupt request lines. Software gives each local source a control register and an 8-bit vector register through a small CPU register port. A control register sets the bus level the source asserts, its enable, and how it answers an acknowledge. A source raises its request by asserting its local input while enabled. The block latches that request as a pending flag and pulls the request line for the programmed level low.

A bus interrupt handler answers with an acknowledge cycle. It drives the acknowledge input low and puts the level it serves on the address lines. The block joins the acknowledge daisy-chain. Once the chain input reaches it, it takes one of two paths. If it has no matching source, it passes the chain on. If it has one, it either returns the source's vector with a data acknowledge or hands the cycle to the device through an external-acknowledge enable and a 2-bit source code. Sources that share a level are served one per acknowledge cycle, lowest-numbered first.

The CPU port and the acknowledge interface are level-handshaked bus signals rather than streams. Each access or acknowledge response is held until the initiator releases its strobe (chip select or acknowledge). Nothing is buffered at the block's edge.

Top module: `bus_intr_ctl`

## Requirements
- R1: After reset, all seven request outputs, the chain output, data acknowledge and the external-acknowledge enable are high, `rdata` and `xack_src` are zero, and every control and vector register reads as zero.
- R2: When `cs_n` is low and `iack_n` is high, an access takes place. Address values 0 to 3 select control registers 0 to 3 and values 4 to 7 select vector registers 0 to 3, with `rw`=1 for a read. `dtack_n` goes low the next cycle and stays low until `cs_n` rises, and `rdata` shows the addressed register throughout. A control register stores level in bits 2:0, external mode in bit 3 and enable in bit 4, and it reads bits 7:5 as zero.
- R3: A source's pending flag is set in any cycle where its `dev_req` input is high while its enable bit is 1. With the enable bit at 0, no flag is set. Request output `irq_n[L]` is low exactly while some source with enable 1, pending flag set and level L exists.
- R4: A source programmed with level 0 asserts no request output and never matches an acknowledge, even at address level 0.
- R5: A control-register write with bit 5 set clears that source's pending flag. Bit 5 is not stored.
- R6: If the chain input stays high during an acknowledge cycle, the block drives nothing, and pending flags are kept.
- R7: If the chain input goes low and no enabled pending source has the acknowledged level, `chain_out_n` goes low the following cycle and stays low until `iack_n` rises.
- R8: On a match whose external bit is 0, `rdata` carries that source's vector and `dtack_n` is low from the cycle after the chain input was seen low until `iack_n` rises. The chain output stays high.
- R9: On a match whose external bit is 1, `xack_en_n` is low and `xack_src` holds the source index until `iack_n` rises. `chain_out_n` and `dtack_n` stay high.
- R10: Among several matching sources, the lowest-numbered one is served. Its pending flag clears when `iack_n` rises, so the shared request line stays low until every source at that level has been served.
- R11: Register accesses attempted while `iack_n` is low are ignored and get no data acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Register port select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address, or acknowledged level during an acknowledge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or supplied vector |
| dtack_n | output | 1 | Data acknowledge, active low |
| dev_req | input | 4 | Local device requests, active high |
| irq_n | output | 7 | Bus request lines, levels 7..1, active low |
| iack_n | input | 1 | Bus interrupt acknowledge, active low |
| chain_in_n | input | 1 | Daisy-chain input, active low |
| chain_out_n | output | 1 | Daisy-chain output, active low |
| xack_en_n | output | 1 | External-acknowledge enable, active low |
| xack_src | output | 2 | Index of the source handed to the device |

## Verification
The bench puts two sources on one level, one vectored and one external. A design that picks the wrong source, or clears the wrong flag, would either return the second vector first or drop the shared request line after the first acknowledge. It also aims at a level-0 source that is enabled and pending, and acknowledges level 0. A design that compares raw levels would answer that cycle instead of passing the chain. Further stimulus covers an acknowledge whose chain input never arrives, a register write attempted while an acknowledge is in progress, a request raised while its enable is off, and a write that sets the clear bit. In each case a faulty design would lose or invent a pending request, or corrupt a vector register.

// File: rtl/bvi_pkg.sv
package bvi_pkg;
  // Control register field positions (level occupies the low bits)
  localparam int CTL_EXT = 3;
  localparam int CTL_IEN = 4;
  localparam int CTL_CLR = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG,
    ST_WAIT,
    ST_PASS,
    ST_INT,
    ST_EXT
  } ack_st_t;
endpackage

// File: rtl/bvi_regs.sv
module bvi_regs
  import bvi_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int DW   = 8,
  parameter int LW   = 3,
  localparam int SW  = $clog2(NSRC),
  localparam int AW  = SW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iack_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic [NSRC-1:0]          dev_req,
  input  logic                     done_en,
  input  logic [SW-1:0]            done_src,
  output logic [NSRC-1:0][LW-1:0]  lvl_o,
  output logic [NSRC-1:0]          ext_o,
  output logic [NSRC-1:0]          active_o,
  output logic [NSRC-1:0][DW-1:0]  vec_o
);
  logic [NSRC-1:0][LW-1:0] lvl_q;
  logic [NSRC-1:0]         ext_q, ien_q, pend_q, clr;
  logic [NSRC-1:0][DW-1:0] vec_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic ctl_hit, vec_hit;
    assign ctl_hit = wr_en && !wr_addr[SW] && (wr_addr[SW-1:0] == SW'(i));
    assign vec_hit = wr_en &&  wr_addr[SW] && (wr_addr[SW-1:0] == SW'(i));
    assign clr[i]  = (done_en && (done_src == SW'(i))) || (ctl_hit && wr_data[CTL_CLR]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i]  <= '0;
        ext_q[i]  <= 1'b0;
        ien_q[i]  <= 1'b0;
        vec_q[i]  <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (ctl_hit) begin
          lvl_q[i] <= wr_data[LW-1:0];
          ext_q[i] <= wr_data[CTL_EXT];
          ien_q[i] <= wr_data[CTL_IEN];
        end
        if (vec_hit) vec_q[i] <= wr_data;
        pend_q[i] <= (pend_q[i] | (dev_req[i] & ien_q[i])) & ~clr[i];
      end
    end

    // A disabled, idle source cannot become pending
    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !ien_q[i]) |=> !pend_q[i]);
  end

  assign lvl_o    = lvl_q;
  assign ext_o    = ext_q;
  assign vec_o    = vec_q;
  assign active_o = pend_q & ien_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr[SW]) begin
      rd_data = vec_q[rd_addr[SW-1:0]];
    end else begin
      rd_data[LW-1:0] = lvl_q[rd_addr[SW-1:0]];
      rd_data[CTL_EXT] = ext_q[rd_addr[SW-1:0]];
      rd_data[CTL_IEN] = ien_q[rd_addr[SW-1:0]];
    end
  end

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_en |=> !pend_q[$past(done_src)]);

  assert_no_write_in_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_n |=> ($stable(vec_q) && $stable(lvl_q) && $stable(ien_q) && $stable(ext_q)));
endmodule

// File: rtl/bvi_route.sv
module bvi_route #(
  parameter int NSRC = 4,
  parameter int NLVL = 7,
  parameter int LW   = 3,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         active,
  input  logic [NSRC-1:0][LW-1:0] lvl,
  input  logic [LW-1:0]           ack_lvl,
  output logic [NLVL:1]           irq_n,
  output logic                    hit_any,
  output logic [SW-1:0]           hit_src
);
  logic [NSRC-1:0] hit;

  for (genvar l = 1; l <= NLVL; l++) begin : g_lvl
    logic [NSRC-1:0] on_lvl;
    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
      assign on_lvl[i] = active[i] && (lvl[i] == LW'(l));
    end
    assign irq_n[l] = ~|on_lvl;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = active[i] && (lvl[i] != '0) && (lvl[i] == ack_lvl);
  end

  // lowest-numbered match wins
  always_comb begin
    hit_src = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i]) hit_src = SW'(i);
    end
  end
  assign hit_any = |hit;

  assert_lvl0_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (ack_lvl != '0));

  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (&irq_n));
endmodule

// File: rtl/bvi_ack_fsm.sv
module bvi_ack_fsm
  import bvi_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int LW   = 3,
  localparam int SW  = $clog2(NSRC),
  localparam int AW  = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic          iack_n,
  input  logic          chain_in_n,
  input  logic          hit_any,
  input  logic [SW-1:0] hit_src,
  input  logic          hit_ext,
  output ack_st_t       st,
  output logic [LW-1:0] ack_lvl,
  output logic [AW-1:0] reg_addr,
  output logic [SW-1:0] src_q,
  output logic          wr_en,
  output logic          done_en,
  output logic          chain_out_n,
  output logic          dtack_n,
  output logic          xack_en_n
);
  ack_st_t st_n;

  assign wr_en   = (st == ST_IDLE) && iack_n && !cs_n && !rw;
  assign done_en = ((st == ST_INT) || (st == ST_EXT)) && iack_n;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if (!iack_n) st_n = ST_WAIT;
               else if (!cs_n) st_n = ST_REG;
      ST_REG:  if (cs_n) st_n = ST_IDLE;
      ST_WAIT: if (iack_n) st_n = ST_IDLE;
               else if (!chain_in_n) st_n = !hit_any ? ST_PASS : (hit_ext ? ST_EXT : ST_INT);
      ST_PASS, ST_INT, ST_EXT: if (iack_n) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ack_lvl  <= '0;
      reg_addr <= '0;
      src_q    <= '0;
    end else begin
      st <= st_n;
      if (st == ST_IDLE && !iack_n) ack_lvl <= addr[LW-1:0];
      if (st == ST_IDLE && iack_n && !cs_n) reg_addr <= addr;
      if (st == ST_WAIT && !iack_n && !chain_in_n) src_q <= hit_src;
    end
  end

  assign chain_out_n = (st != ST_PASS);
  assign dtack_n     = !((st == ST_INT) || (st == ST_REG));
  assign xack_en_n   = (st != ST_EXT);

  assert_resp_needs_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && chain_in_n) |=> (st == ST_WAIT || st == ST_IDLE));

  assert_hold_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INT && !iack_n) |=> (!dtack_n && $stable(src_q)));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!chain_out_n, !xack_en_n, !dtack_n}) <= 1);

  assert_pass_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_out_n && !iack_n) |=> !chain_out_n);
endmodule

// File: rtl/bus_intr_ctl.sv
module bus_intr_ctl
  import bvi_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NLVL = 7,
  parameter int DW   = 8,
  localparam int SW  = $clog2(NSRC),
  localparam int AW  = SW + 1,
  localparam int LW  = $clog2(NLVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rw,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            dtack_n,
  input  logic [NSRC-1:0] dev_req,
  output logic [NLVL:1]   irq_n,
  input  logic            iack_n,
  input  logic            chain_in_n,
  output logic            chain_out_n,
  output logic            xack_en_n,
  output logic [SW-1:0]   xack_src
);
  ack_st_t                 st;
  logic [LW-1:0]           ack_lvl;
  logic [AW-1:0]           reg_addr;
  logic [SW-1:0]           src_q, hit_src, done_src;
  logic                    wr_en, done_en, hit_any;
  logic [DW-1:0]           reg_rd;
  logic [NSRC-1:0][LW-1:0] lvl;
  logic [NSRC-1:0]         ext, active;
  logic [NSRC-1:0][DW-1:0] vec;

  assign done_src = src_q;

  bvi_regs #(.NSRC(NSRC), .DW(DW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .iack_n(iack_n),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
    .rd_addr(reg_addr), .rd_data(reg_rd),
    .dev_req(dev_req), .done_en(done_en), .done_src(done_src),
    .lvl_o(lvl), .ext_o(ext), .active_o(active), .vec_o(vec)
  );

  bvi_route #(.NSRC(NSRC), .NLVL(NLVL), .LW(LW)) u_route (
    .clk(clk), .rst_n(rst_n), .active(active), .lvl(lvl), .ack_lvl(ack_lvl),
    .irq_n(irq_n), .hit_any(hit_any), .hit_src(hit_src)
  );

  bvi_ack_fsm #(.NSRC(NSRC), .LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .iack_n(iack_n), .chain_in_n(chain_in_n),
    .hit_any(hit_any), .hit_src(hit_src), .hit_ext(ext[hit_src]),
    .st(st), .ack_lvl(ack_lvl), .reg_addr(reg_addr), .src_q(src_q),
    .wr_en(wr_en), .done_en(done_en),
    .chain_out_n(chain_out_n), .dtack_n(dtack_n), .xack_en_n(xack_en_n)
  );

  always_comb begin
    unique case (st)
      ST_INT:  rdata = vec[src_q];
      ST_REG:  rdata = reg_rd;
      default: rdata = '0;
    endcase
  end
  assign xack_src = (st == ST_EXT) ? src_q : '0;

  assert_ext_src_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xack_en_n && !iack_n) |=> (!xack_en_n && $stable(xack_src)));
endmodule

// File: tb/bus_intr_ctl_bench.sv
module bus_intr_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rw = 1'b1, iack_n = 1'b1, chain_in_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] dev_req = '0;
  logic [7:0] rdata;
  logic       dtack_n, chain_out_n, xack_en_n;
  logic [7:1] irq_n;
  logic [1:0] xack_src;

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;

  always #5 clk = ~clk;

  bus_intr_ctl u_bus_intr_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dtack_n(dtack_n), .dev_req(dev_req), .irq_n(irq_n),
    .iack_n(iack_n), .chain_in_n(chain_in_n), .chain_out_n(chain_out_n),
    .xack_en_n(xack_en_n), .xack_src(xack_src)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 idle, 1 register access, 2 await chain, 3 pass, 4 vector, 5 external
  int m_st = 0, m_lvl = 0, m_src = 0, m_raddr = 0;
  int m_level[4] = '{0, 0, 0, 0};
  bit m_ext[4]   = '{0, 0, 0, 0};
  bit m_en[4]    = '{0, 0, 0, 0};
  bit m_pend[4]  = '{0, 0, 0, 0};
  int m_vec[4]   = '{0, 0, 0, 0};

  function automatic int m_reg(input int a);
    if (a >= 4) return m_vec[a - 4];
    return m_level[a] + (m_ext[a] ? 8 : 0) + (m_en[a] ? 16 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_lvl = 0; m_src = 0; m_raddr = 0;
      for (int i = 0; i < 4; i++) begin
        m_level[i] = 0; m_ext[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_vec[i] = 0;
      end
    end else begin
      bit nxt_pend[4];
      bit old_en[4];
      int found;
      for (int i = 0; i < 4; i++) begin
        old_en[i] = m_en[i];
        nxt_pend[i] = m_pend[i] | (dev_req[i] & m_en[i]);
      end
      case (m_st)
        0: if (!iack_n) begin m_lvl = addr; m_st = 2; end
           else if (!cs_n) begin
             m_raddr = addr; m_st = 1;
             if (!rw) begin
               if (addr >= 4) m_vec[addr - 4] = wdata;
               else begin
                 m_level[addr] = wdata[2:0]; m_ext[addr] = wdata[3]; m_en[addr] = wdata[4];
                 if (wdata[5]) nxt_pend[addr] = 0;
               end
             end
           end
        1: if (cs_n) m_st = 0;
        2: if (iack_n) m_st = 0;
           else if (!chain_in_n) begin
             found = -1;
             for (int i = 3; i >= 0; i--)
               if (m_pend[i] && old_en[i] && m_level[i] != 0 && m_level[i] == m_lvl) found = i;
             if (found < 0) m_st = 3;
             else begin m_src = found; m_st = m_ext[found] ? 5 : 4; end
           end
        3: if (iack_n) m_st = 0;
        default: if (iack_n) begin nxt_pend[m_src] = 0; m_st = 0; end
      endcase
      for (int i = 0; i < 4; i++) m_pend[i] = nxt_pend[i];
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      logic [7:1] e_irq;
      e_irq = '1;
      for (int i = 0; i < 4; i++)
        if (m_pend[i] && m_en[i] && m_level[i] != 0) e_irq[m_level[i]] = 1'b0;
      check(irq_n === e_irq, "R3 irq_n model", irq_n, e_irq);
      check(chain_out_n === (m_st != 3), "R7 chain_out_n model", chain_out_n, m_st != 3);
      check(dtack_n === !(m_st == 4 || m_st == 1), "R8 dtack_n model", dtack_n, !(m_st == 4 || m_st == 1));
      check(rdata === 8'((m_st == 4) ? m_vec[m_src] : (m_st == 1) ? m_reg(m_raddr) : 0),
            "R2 rdata model", rdata, (m_st == 4) ? m_vec[m_src] : (m_st == 1) ? m_reg(m_raddr) : 0);
      check(xack_en_n === (m_st != 5), "R9 xack_en_n model", xack_en_n, m_st != 5);
      check(xack_src === 2'((m_st == 5) ? m_src : 0), "R9 xack_src model", xack_src, (m_st == 5) ? m_src : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cpu_access(input bit rd, input int a, input int d, output int q);
    @(negedge clk);
    cs_n = 1'b0; rw = rd; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    while (dtack_n) @(negedge clk);
    q = rdata;
    cs_n = 1'b1; rw = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    int q;
    cpu_access(0, a, d, q);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); dev_req[i] = 1'b1;
    @(negedge clk); dev_req[i] = 1'b0;
    @(negedge clk);
  endtask

  int o_chain, o_dtack, o_rdata, o_xen, o_xsrc;
  task automatic ack(input int lvl, input bit chain);
    @(negedge clk); iack_n = 1'b0; addr = 3'(lvl);
    @(negedge clk); if (chain) chain_in_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    o_chain = chain_out_n; o_dtack = dtack_n; o_rdata = rdata; o_xen = xack_en_n; o_xsrc = xack_src;
    iack_n = 1'b1; chain_in_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int q;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq_n === 7'h7f && chain_out_n && dtack_n && xack_en_n && rdata == 0 && xack_src == 0,
          "R1 reset outputs", {irq_n, chain_out_n, dtack_n, xack_en_n}, 10'h3ff);
    rst_n = 1'b1;
    cmp_on = 1;
    cpu_access(1, 0, 0, q); check(q == 0, "R1 ctrl0 after reset", q, 0);
    cpu_access(1, 6, 0, q); check(q == 0, "R1 vec2 after reset", q, 0);

    // R2 register map and field layout
    wr(0, 8'hD3);                       // level 3, enable, bits 7:6 dropped
    wr(1, 8'h1B);                       // level 3, external, enable
    wr(2, 8'h15);                       // level 5, enable
    wr(3, 8'h10);                       // level 0, enable
    wr(4, 8'h40); wr(5, 8'h41); wr(6, 8'h42); wr(7, 8'h43);
    cpu_access(1, 0, 0, q); check(q == 8'h13, "R2 ctrl0 readback", q, 8'h13);
    cpu_access(1, 1, 0, q); check(q == 8'h1B, "R2 ctrl1 readback", q, 8'h1B);
    cpu_access(1, 5, 0, q); check(q == 8'h41, "R2 vec1 readback", q, 8'h41);

    // R4 level-0 source stays silent and is not matched
    pulse(3);
    check(irq_n === 7'h7f, "R4 level0 no request", irq_n, 7'h7f);
    ack(0, 1);
    check(o_chain == 0 && o_dtack == 1 && o_xen == 1, "R4 level0 ack passes chain",
          {o_chain[0], o_dtack[0], o_xen[0]}, 3'b011);

    // R3 requests on a shared level
    pulse(0); pulse(1);
    check(irq_n[3] == 0 && irq_n[5] == 1, "R3 level3 asserted", irq_n, 7'h7b);

    // R6 no chain input: nothing happens, pending kept
    ack(3, 0);
    check(o_chain == 1 && o_dtack == 1 && o_xen == 1, "R6 silent without chain",
          {o_chain[0], o_dtack[0], o_xen[0]}, 3'b111);
    check(irq_n[3] == 0, "R6 pending kept", irq_n[3], 0);

    // R10 + R8: lowest source first, internal vector
    ack(3, 1);
    check(o_dtack == 0 && o_rdata == 8'h40 && o_chain == 1, "R8 internal vector src0", o_rdata, 8'h40);
    check(irq_n[3] == 0, "R10 level held for src1", irq_n[3], 0);
    // R9 external handoff for src1
    ack(3, 1);
    check(o_xen == 0 && o_xsrc == 1 && o_chain == 1 && o_dtack == 1, "R9 external src1", o_xsrc, 1);
    check(irq_n[3] == 1, "R10 level released after all served", irq_n[3], 1);
    // R7 nothing left at level 3
    ack(3, 1);
    check(o_chain == 0 && o_dtack == 1 && o_xen == 1, "R7 pass when empty", o_chain, 0);

    // R5 clear bit
    pulse(2);
    check(irq_n[5] == 0, "R5 level5 raised", irq_n[5], 0);
    wr(2, 8'h35);
    check(irq_n[5] == 1, "R5 cleared by write", irq_n[5], 1);
    cpu_access(1, 2, 0, q); check(q == 8'h15, "R5 clear bit not stored", q, 8'h15);

    // R3 disabled source does not latch
    wr(0, 8'h03);
    pulse(0);
    wr(0, 8'h13);
    check(irq_n[3] == 1, "R3 no latch while disabled", irq_n[3], 1);

    // R11 access during acknowledge ignored
    @(negedge clk); iack_n = 1'b0; addr = 3'd4;
    @(negedge clk); cs_n = 1'b0; rw = 1'b0; wdata = 8'hFF;
    @(negedge clk); @(negedge clk);
    check(dtack_n == 1, "R11 no dtack during ack", dtack_n, 1);
    cs_n = 1'b1; rw = 1'b1;
    @(negedge clk); iack_n = 1'b1;
    @(negedge clk); @(negedge clk);
    cpu_access(1, 4, 0, q); check(q == 8'h40, "R11 vec0 unchanged", q, 8'h40);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule